// File: doc/BRIEF.md
# Column Power Pulsing Sequencer

This block switches the bias of a pixel matrix on and off one double column group at a time, so that the analog supply current ramps instead of stepping. Raising the power enable starts a ramp that switches columns on from column 0 upward. Lowering it starts a ramp that switches them off from the highest lit column downward. The configuration word sets the ramp speed separately for each direction. Each direction has a step period, in cycles of the 40 MHz system clock, and a group size, which is the number of columns that switch together at each step.

When the last column of an on ramp switches, the block emits a one-cycle completion event that carries a fixed 16-bit tag. An optional mode stops the pixel-matrix clock once an off ramp has completed. The clock is enabled again as soon as a new on ramp is requested, before any column is powered. If the enable reverses in the middle of a ramp, the sequence turns around at the column it has reached.

Top module: `col_pulse_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `col_sel` is all zeros, `mclk_en` is 1, `on_done` is 0 and `done_tag` is 0.
- R2: The configuration word `cfg_word` is laid out as follows:
  - bits [2:0]: on-ramp step divider.
  - bits [5:3]: on-ramp group field.
  - bits [8:6]: off-ramp step divider.
  - bits [11:9]: off-ramp group field.
  - bit 12: clock-gating enable.

  Each step moves 2^group columns. The position saturates at 128 on the way up and at 0 on the way down.
- R3: One step is taken every 2^divider clock cycles. Let S = ceil(128 / 2^group) be the number of steps in a full ramp. If `pwr_en` changes ahead of clock edge k, the full ramp completes on edge k + S·2^divider.
- R4: `col_sel` is always a thermometer code that is filled from bit 0. Columns turn on in ascending index order and turn off in descending index order.
- R5: `on_done` is a single-cycle pulse. It is asserted in the same cycle that `col_sel` first becomes all ones on an on ramp. `done_tag` reads 16'h3F3F in that cycle and 0 in every other cycle.
- R6: With bit 12 set, `mclk_en` drops one cycle after an off ramp has brought `col_sel` to zero. It is never 0 while any column is selected.
- R7: With bit 12 clear, `mclk_en` stays at 1 whatever `pwr_en` does.
- R8: After `pwr_en` rises, `mclk_en` is 1 on the next clock edge, while `col_sel` is still zero.
- R9: If `pwr_en` flips during a ramp, the ramp reverses from the current column position. No column is skipped and nothing restarts from an end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 13 | Ramp and gating configuration (R2) |
| pwr_en | input | 1 | Power-pulsing enable: high = power on, low = power off |
| col_sel | output | 128 | Per-column bias select, 1 = on-state bias |
| mclk_en | output | 1 | Pixel-matrix clock enable |
| on_done | output | 1 | One-cycle on-ramp completion event |
| done_tag | output | 16 | Completion tag, valid while `on_done` is high |

## Verification
Two events can fall on the same clock edge: a step tick, and a flip of `pwr_en` that clears the step timer. In that case the step still moves in the old direction before the ramp turns around. The bench provokes this collision with a one-cycle step period. It reverses the enable after nine columns are lit. It then judges the result by the exact number of edges the off ramp takes to empty `col_sel`, which is eleven, and by the thermometer pattern seen just before the reversal. A second collision is between completion of the off ramp and the clock-gating decision. This is judged by sampling `mclk_en` in the cycle `col_sel` reaches zero and again one cycle later.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int FLD_W = 3;

  // configuration word, MSB first
  typedef struct packed {
    logic             gate;
    logic [FLD_W-1:0] dn_grp;
    logic [FLD_W-1:0] dn_div;
    logic [FLD_W-1:0] up_grp;
    logic [FLD_W-1:0] up_div;
  } cps_cfg_t;

  localparam int CFG_W = $bits(cps_cfg_t);
endpackage

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
  parameter int FLD_W = 3,
  localparam int CW = (1 << FLD_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [FLD_W-1:0] div_log,
  output logic             tick
);
  logic [CW-1:0] cnt;
  logic [CW:0]   limit_w;
  logic [CW-1:0] limit;

  always_comb begin
    limit_w = ((CW+1)'(1) << div_log) - (CW+1)'(1);
    limit   = limit_w[CW-1:0];
    tick    = run && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run || tick) cnt <= '0;
    else                              cnt <= cnt + CW'(1);
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> cnt == '0); // R3
endmodule

// File: rtl/cps_position.sv
module cps_position #(
  parameter int NUM_COLS = 128,
  parameter int FLD_W = 3,
  localparam int PW = $clog2(NUM_COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             tick,
  input  logic [FLD_W-1:0] grp_log,
  output logic [PW-1:0]    pos,
  output logic [PW-1:0]    pos_nxt,
  output logic             at_goal
);
  localparam logic [PW:0] FULL = (PW+1)'(NUM_COLS);

  logic [PW:0]   grp, sum, dif;
  logic [PW-1:0] pos_up, pos_dn;

  always_comb begin
    grp     = (PW+1)'(1) << grp_log;
    sum     = {1'b0, pos} + grp;
    dif     = {1'b0, pos} - grp;
    pos_up  = (sum >= FULL) ? FULL[PW-1:0] : sum[PW-1:0];
    pos_dn  = ({1'b0, pos} <= grp) ? '0 : dif[PW-1:0];
    at_goal = up ? (pos == FULL[PW-1:0]) : (pos == '0);
    pos_nxt = (tick && !at_goal) ? (up ? pos_up : pos_dn) : pos;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= pos_nxt;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, pos} <= FULL); // R2
  AST_UP_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    $past(up) |-> pos >= $past(pos)); // R9
  AST_DN_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    !$past(up) |-> pos <= $past(pos)); // R9
endmodule

// File: rtl/cps_col_decode.sv
module cps_col_decode #(
  parameter int NUM_COLS = 128,
  localparam int PW = $clog2(NUM_COLS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       pos_nxt,
  output logic [NUM_COLS-1:0] col_sel
);
  for (genvar i = 0; i < NUM_COLS; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst) col_sel[i] <= 1'b0;
      else     col_sel[i] <= (pos_nxt > PW'(i));
    end
  end
endmodule

// File: rtl/col_pulse_seq.sv
module col_pulse_seq
  import cps_pkg::*;
#(
  parameter int          NUM_COLS = 128,
  parameter logic [15:0] DONE_TAG = 16'h3F3F,
  localparam int PW = $clog2(NUM_COLS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic                pwr_en,
  output logic [NUM_COLS-1:0] col_sel,
  output logic                mclk_en,
  output logic                on_done,
  output logic [15:0]         done_tag
);
  cps_cfg_t         cfg;
  logic             en_q;
  logic [FLD_W-1:0] sel_div, sel_grp;
  logic             tick, at_goal;
  logic [PW-1:0]    pos, pos_nxt;

  assign cfg = cps_cfg_t'(cfg_word);

  always_comb begin
    sel_div = en_q ? cfg.up_div : cfg.dn_div;
    sel_grp = en_q ? cfg.up_grp : cfg.dn_grp;
  end

  cps_step_timer #(.FLD_W(FLD_W)) u_timer (
    .clk(clk), .rst(rst), .run(!at_goal), .clear(pwr_en ^ en_q),
    .div_log(sel_div), .tick(tick));

  cps_position #(.NUM_COLS(NUM_COLS), .FLD_W(FLD_W)) u_pos (
    .clk(clk), .rst(rst), .up(en_q), .tick(tick), .grp_log(sel_grp),
    .pos(pos), .pos_nxt(pos_nxt), .at_goal(at_goal));

  cps_col_decode #(.NUM_COLS(NUM_COLS)) u_dec (
    .clk(clk), .rst(rst), .pos_nxt(pos_nxt), .col_sel(col_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mclk_en  <= 1'b1;
      on_done  <= 1'b0;
      done_tag <= '0;
    end else begin
      en_q    <= pwr_en;
      mclk_en <= !(cfg.gate && !pwr_en && !en_q && pos == '0);
      on_done <= en_q && (pos != PW'(NUM_COLS)) && (pos_nxt == PW'(NUM_COLS));
      done_tag <= (en_q && (pos != PW'(NUM_COLS)) && (pos_nxt == PW'(NUM_COLS)))
                  ? DONE_TAG : '0;
    end
  end

  AST_THERMO: assert property (@(posedge clk) disable iff (rst)
    (col_sel & (col_sel + NUM_COLS'(1))) == '0); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
    on_done |-> &col_sel); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    on_done |=> !on_done); // R5
  AST_GATE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !mclk_en |-> col_sel == '0); // R6
  AST_NO_GATE_CFG: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.gate) |-> mclk_en); // R7
  AST_CLK_BACK: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_en) |-> mclk_en); // R8
endmodule

// File: tb/col_pulse_seq_bench.sv
module col_pulse_seq_bench;
  localparam int NC = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [12:0]   cfg_word = '0;
  logic          pwr_en = 1'b0;
  logic [NC-1:0] col_sel;
  logic          mclk_en, on_done;
  logic [15:0]   done_tag;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  col_pulse_seq u_col_pulse_seq (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .pwr_en(pwr_en),
    .col_sel(col_sel), .mclk_en(mclk_en), .on_done(on_done),
    .done_tag(done_tag));

  // {cfg, expected on-ramp edges, expected off-ramp edges}
  typedef struct packed {
    logic [12:0] cfg;
    int          up_n;
    int          dn_n;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{13'h1E38,    2,   2},
    '{13'h0A63,   65,   9},
    '{13'h1680,  129,  65},
    '{13'h1DFF,  129, 257},
    '{13'h0215, 1025,  65}
  };

  task automatic chk(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick1();
    // R1 reset state
    chk("R1 col_sel", col_sel, '0);
    chk("R1 mclk_en", NC'(mclk_en), NC'(1));
    chk("R1 on_done", NC'(on_done), '0);
    rst = 1'b0;
    tick1();
    chk("R1 after release", NC'({mclk_en, on_done, |col_sel, |done_tag}), NC'(4'b1000));

    foreach (VECS[v]) begin
      cfg_word = VECS[v].cfg;
      tick1();
      pwr_en = 1'b1;
      n = 0;
      tick1(); n++;
      // R8: clock back before any column
      chk("R8 clk_en", NC'(mclk_en), NC'(1));
      chk("R8 no column yet", col_sel, '0);
      while (!on_done && n < 3000) begin tick1(); n++; end
      chk("R3 up ramp edges", NC'(n), NC'(VECS[v].up_n));
      chk("R5 full on done", col_sel, '1);
      chk("R5 tag", NC'(done_tag), NC'(16'h3F3F));
      tick1();
      chk("R5 pulse end", NC'({on_done, done_tag}), '0);
      pwr_en = 1'b0;
      n = 0;
      do begin tick1(); n++; end while (col_sel != '0 && n < 3000);
      chk("R3 R2 down ramp edges", NC'(n), NC'(VECS[v].dn_n));
      chk("R6 clk kept while emptying", NC'(mclk_en), NC'(1));
      tick1();
      chk("R6 R7 gate after off", NC'(mclk_en), NC'(!VECS[v].cfg[12]));
    end

    // R7: gate bit clear, enable idle low: clock stays on
    cfg_word = 13'h0000;
    repeat (4) tick1();
    chk("R7 stays enabled", NC'(mclk_en), NC'(1));

    // R9 / R4: reversal mid-ramp, one column per cycle both ways
    cfg_word = 13'h1000;
    tick1();
    pwr_en = 1'b1;
    repeat (10) tick1();
    chk("R4 thermometer at 9", col_sel, NC'(9'h1FF));
    pwr_en = 1'b0;
    n = 0;
    do begin tick1(); n++; end while (col_sel != '0 && n < 3000);
    chk("R9 reversal edges", NC'(n), NC'(11));
    tick1();
    chk("R6 gated after reversal", NC'(mclk_en), NC'(0));

    // R4: partial off ramp empties from the top
    cfg_word = 13'h1008;
    tick1();
    pwr_en = 1'b1;
    n = 0;
    while (!on_done && n < 3000) begin tick1(); n++; end
    pwr_en = 1'b0;
    cfg_word = 13'h1208;
    tick1(); tick1();
    chk("R4 top columns off first", col_sel, {2'b00, {(NC-2){1'b1}}});

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule